// File: doc/BRIEF.md
# Serial Read-Only Memory Slave

This block is a slave on a four-wire serial bus: an active-low select, a serial clock, a data input and a data output. It serves reads from a small constant byte store. The master sends a one-byte opcode with the most significant bit first. There are three valid opcodes:

- A plain read takes a 24-bit address, sent as three bytes with the high byte first.
- A fast read takes the same address and then one ignored padding byte.
- An identification read returns a fixed three-byte signature.

After a read header, bytes stream out from consecutive locations for as long as select stays low. Any other opcode parks the slave with its output released until the next select cycle.

The serial clock, select and data input pass through a two-flop synchronizer into the system clock domain. Edges of the serial clock are detected there. Input bits are taken on rising serial-clock edges. Output bits change after falling edges. The output enable tells the pad when to drive the line.

The system clock must run at least eight times faster than the serial clock. This gives the falling-edge output path, about three system cycles, time to settle before the master samples on the next rising edge.

Top module: `spi_rom_slave`

## Requirements
- R1: Out of reset, and within three system cycles of select going high, `sdo_oe_o` is 0. Serial clock edges seen while select is high have no effect.
- R2: Opcode 0x03 is followed by three address bytes. From the first falling serial-clock edge after the last address bit, the slave drives the byte at that address with the output enable high.
- R3: Opcode 0x0B is followed by three address bytes and one padding byte whose value is ignored. Data then starts as in R2.
- R4: Opcode 0x9F returns the bytes 0xAE, 0x41 and 0x16, in that order.
- R5: After the third identification byte, every further byte read is 0x00 until select rises.
- R6: While select stays low, each further byte comes from the next location. The location after DEPTH-1 is 0.
- R7: Only the low log2(DEPTH) address bits select a location. Higher address bits are ignored, so address A reads location A mod DEPTH.
- R8: An opcode other than 0x03, 0x0B or 0x9F keeps `sdo_oe_o` at 0 for the rest of that transaction. The next transaction after select rises is decoded normally.
- R9: Every byte in both directions is sent most significant bit first. `sdo_o` changes only in the system cycle that follows a detected falling serial-clock edge.
- R10: With the default DEPTH of 256, location i holds ((i*37 + 11) xor (i >> 5)) mod 256.
- R11: Raising select in the middle of any byte aborts the transaction. The next transaction again starts with an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low slave select |
| sck_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master |
| sdo_oe_o | output | 1 | Output enable for the `sdo_o` pad; 0 means high impedance |

## Verification
The bound checker watches four things on every cycle:

- The output is released one cycle after select is seen high.
- `sdo_o` holds still except after a falling serial-clock edge.
- A parked slave stays parked while select is low.
- The output enable rises only after a sampled rising serial-clock edge.

Only the bench scenarios can show the data itself. These include the byte values for random and chosen addresses, the address wrap and aliasing, the padding byte on a fast read, the identification bytes followed by zeros, and a clean restart after a transaction is aborted or rejected.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_ID   = 8'h9F;

  localparam logic [7:0] ID_MFR  = 8'hAE;
  localparam logic [7:0] ID_TYPE = 8'h41;
  localparam logic [7:0] ID_CAP  = 8'h16;

  localparam int ADDR_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_PAD,
    ST_DATA,
    ST_ID,
    ST_REJ
  } spi_state_e;

  function automatic logic [7:0] rom_byte(input int unsigned i);
    return 8'((i * 37 + 11) ^ (i >> 5));
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

endmodule

// File: rtl/spi_rom_array.sv
module spi_rom_array
  import spi_rom_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       data_o
);

  localparam int IMG_W = DEPTH * 8;

  function automatic logic [IMG_W-1:0] build_img();
    logic [IMG_W-1:0] img;
    img = '0;
    for (int i = 0; i < DEPTH; i++) img[i*8 +: 8] = rom_byte(i);
    return img;
  endfunction

  localparam logic [IMG_W-1:0] IMG = build_img();

  assign data_o = IMG[{idx_i, 3'b000} +: 8];

endmodule

// File: rtl/spi_rom_ctrl.sv
module spi_rom_ctrl
  import spi_rom_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_s_i,
  input  logic             sck_s_i,
  input  logic             sdi_s_i,
  output logic [IDX_W-1:0] rom_idx_o,
  input  logic [7:0]       rom_data_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             sel_o,
  output logic             sck_rise_o,
  output logic             sck_fall_o,
  output logic             parked_o
);

  localparam logic [1:0] LAST_HDR = 2'(ADDR_BYTES - 1);

  spi_state_e       state_q;
  logic             sck_q;
  logic [6:0]       rx_sh_q;
  logic [2:0]       rx_cnt_q;
  logic [1:0]       hdr_cnt_q;
  logic             fast_q;
  logic [IDX_W-1:0] addr_sh_q, ptr_q;
  logic [6:0]       tx_sh_q;
  logic [2:0]       tx_cnt_q;
  logic [1:0]       id_cnt_q;
  logic             sdo_q;

  logic             sel, rise, fall, byte_done, tx_act;
  logic [7:0]       rx_byte, nxt_byte;
  logic [IDX_W-1:0] addr_nxt;

  assign sel       = !cs_s_i;
  assign rise      = sck_s_i && !sck_q;
  assign fall      = !sck_s_i && sck_q;
  assign rx_byte   = {rx_sh_q, sdi_s_i};
  assign byte_done = (rx_cnt_q == 3'd7);
  assign addr_nxt  = {addr_sh_q[IDX_W-2:0], sdi_s_i};
  assign tx_act    = (state_q == ST_DATA) || (state_q == ST_ID);

  always_comb begin
    nxt_byte = rom_data_i;
    if (state_q == ST_ID) begin
      unique case (id_cnt_q)
        2'd0:    nxt_byte = ID_MFR;
        2'd1:    nxt_byte = ID_TYPE;
        2'd2:    nxt_byte = ID_CAP;
        default: nxt_byte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sck_q     <= 1'b0;
      rx_sh_q   <= '0;
      rx_cnt_q  <= '0;
      hdr_cnt_q <= '0;
      fast_q    <= 1'b0;
      addr_sh_q <= '0;
      ptr_q     <= '0;
      tx_sh_q   <= '0;
      tx_cnt_q  <= '0;
      id_cnt_q  <= '0;
      sdo_q     <= 1'b0;
    end else begin
      sck_q <= sck_s_i;
      if (!sel) begin
        state_q   <= ST_IDLE;
        rx_cnt_q  <= '0;
        hdr_cnt_q <= '0;
        tx_cnt_q  <= '0;
        id_cnt_q  <= '0;
        sdo_q     <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh_q  <= rx_byte[6:0];
          rx_cnt_q <= rx_cnt_q + 3'd1;
        end
        unique case (state_q)
          ST_IDLE: state_q <= ST_CMD;
          ST_CMD: if (rise && byte_done) begin
            unique case (rx_byte)
              OP_READ: begin state_q <= ST_ADDR; fast_q <= 1'b0; end
              OP_FAST: begin state_q <= ST_ADDR; fast_q <= 1'b1; end
              OP_ID:   state_q <= ST_ID;
              default: state_q <= ST_REJ;
            endcase
          end
          ST_ADDR: if (rise) begin
            addr_sh_q <= addr_nxt;
            if (byte_done) begin
              hdr_cnt_q <= hdr_cnt_q + 2'd1;
              if (hdr_cnt_q == LAST_HDR) begin
                state_q <= fast_q ? ST_PAD : ST_DATA;
                ptr_q   <= addr_nxt;
              end
            end
          end
          ST_PAD: if (rise && byte_done) state_q <= ST_DATA;
          default: ;
        endcase
        // output path: new byte on every eighth falling edge
        if (fall && tx_act) begin
          if (tx_cnt_q == 3'd0) begin
            sdo_q   <= nxt_byte[7];
            tx_sh_q <= nxt_byte[6:0];
            if (state_q == ST_DATA) ptr_q <= ptr_q + IDX_W'(1);
            else if (id_cnt_q != 2'd3) id_cnt_q <= id_cnt_q + 2'd1;
          end else begin
            sdo_q   <= tx_sh_q[6];
            tx_sh_q <= {tx_sh_q[5:0], 1'b0};
          end
          tx_cnt_q <= tx_cnt_q + 3'd1;
        end
      end
    end
  end

  assign rom_idx_o  = ptr_q;
  assign sdo_o      = sdo_q;
  assign sdo_oe_o   = tx_act;
  assign sel_o      = sel;
  assign sck_rise_o = rise;
  assign sck_fall_o = fall;
  assign parked_o   = (state_q == ST_REJ);

endmodule

// File: rtl/spi_rom_slave.sv
module spi_rom_slave #(
  parameter int DEPTH = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [2:0]       sync_q;
  logic [IDX_W-1:0] rom_idx;
  logic [7:0]       rom_data;
  logic             sel, sck_rise, sck_fall, parked;

  spi_sync #(
    .WIDTH   (3),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, sdi_i}),
    .q_o    (sync_q)
  );

  spi_rom_array #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_rom (
    .idx_i  (rom_idx),
    .data_o (rom_data)
  );

  spi_rom_ctrl #(
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (sync_q[2]),
    .sck_s_i    (sync_q[1]),
    .sdi_s_i    (sync_q[0]),
    .rom_idx_o  (rom_idx),
    .rom_data_i (rom_data),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .sel_o      (sel),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .parked_o   (parked)
  );

endmodule

// File: rtl/spi_rom_chk.sv
module spi_rom_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_i,
  input logic sck_rise_i,
  input logic sck_fall_i,
  input logic parked_i,
  input logic sdo_i,
  input logic sdo_oe_i
);

  // R1
  idle_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !sdo_oe_i);

  // R9
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sel_i) && !$past(sck_fall_i)) |-> $stable(sdo_i));

  // R8
  park_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parked_i && sel_i) |=> parked_i);

  // R2
  oe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_i) |-> $past(sck_rise_i));

endmodule

bind spi_rom_slave spi_rom_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel),
  .sck_rise_i (sck_rise),
  .sck_fall_i (sck_fall),
  .parked_i   (parked),
  .sdo_i      (sdo_o),
  .sdo_oe_i   (sdo_oe_o)
);

// File: tb/spi_rom_slave_tb.sv
module spi_rom_slave_tb;

  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sdo, oe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_rom_slave #(.DEPTH(DEPTH)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cs_ni    (cs_n),
    .sck_i    (sck),
    .sdi_i    (sdi),
    .sdo_o    (sdo),
    .sdo_oe_o (oe)
  );

  function automatic logic [7:0] exp_rom(input int unsigned a);
    int unsigned i;
    i = a % DEPTH;
    return 8'((i * 37 + 11) ^ (i >> 5));
  endfunction

  function automatic logic [7:0] exp_id(input int k);
    case (k)
      0: return 8'hAE;
      1: return 8'h41;
      2: return 8'h16;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic r, output logic o);
    sdi = b;
    repeat (7) @(negedge clk);
    r = sdo;
    o = oe;
    sck = 1'b1;
    repeat (8) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oe_all, output logic oe_any);
    logic r, o;
    rx = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(tx[i], r, o);
      rx = {rx[6:0], r};
      oe_all &= o;
      oe_any |= o;
    end
  endtask

  task automatic start();
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic stop();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 released after deselect", oe, 0);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] addr);
    logic [7:0] rx;
    logic a, y;
    xfer(op, rx, a, y);
    xfer(addr[23:16], rx, a, y);
    xfer(addr[15:8], rx, a, y);
    xfer(addr[7:0], rx, a, y);
    if (op == 8'h0B) xfer(8'($urandom), rx, a, y);
  endtask

  task automatic do_read(input logic [7:0] op, input logic [23:0] addr, input int n);
    logic [7:0] rx;
    logic a, y;
    string tag;
    tag = (op == 8'h0B) ? "R3 fast read" : "R2 read";
    start();
    send_hdr(op, addr);
    for (int k = 0; k < n; k++) begin
      xfer(8'($urandom), rx, a, y);
      chk({tag, " R6 R10 data"}, rx, exp_rom(addr + k));
      chk({tag, " oe"}, a, 1);
    end
    stop();
  endtask

  task automatic do_id(input int n);
    logic [7:0] rx;
    logic a, y;
    start();
    xfer(8'h9F, rx, a, y);
    for (int k = 0; k < n; k++) begin
      xfer(8'($urandom), rx, a, y);
      chk((k < 3) ? "R4 id byte" : "R5 id tail", rx, exp_id(k));
      chk("R4 oe", a, 1);
    end
    stop();
  endtask

  task automatic do_bad(input logic [7:0] op);
    logic [7:0] rx;
    logic a, y;
    start();
    xfer(op, rx, a, y);
    chk("R8 opcode byte oe", y, 0);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h03, rx, a, y);
      chk("R8 parked oe", y, 0);
    end
    stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic a, y, r, o;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk("R1 reset oe", oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle oe", oe, 0);
    // clock activity while deselected
    for (int i = 0; i < 8; i++) bit_xfer(1'b1, r, o);
    chk("R1 deselected clocks oe", oe, 0);

    do_read(8'h03, 24'h000000, 3);
    do_read(8'h0B, 24'h000040, 3);
    do_read(8'h03, 24'h0000FE, 4);    // R6 wrap
    do_read(8'h0B, 24'hFFFFFF, 2);    // R6 wrap, R7 alias
    do_read(8'h03, 24'h123456, 2);    // R7 alias
    do_id(3);
    do_id(6);                          // R5
    do_bad(8'h5A);
    do_read(8'h03, 24'h000080, 2);    // R8 recovery
    do_bad(8'h02);
    do_id(2);

    // R11: abort inside a data byte
    start();
    send_hdr(8'h03, 24'h000010);
    xfer(8'h00, rx, a, y);
    chk("R11 pre-abort data", rx, exp_rom(24'h10));
    for (int i = 0; i < 3; i++) bit_xfer(1'b0, r, o);
    stop();
    do_read(8'h03, 24'h000020, 2);
    // R11: abort inside the address
    start();
    xfer(8'h0B, rx, a, y);
    xfer(8'h00, rx, a, y);
    for (int i = 0; i < 5; i++) bit_xfer(1'b1, r, o);
    stop();
    do_read(8'h0B, 24'h0000C3, 2);

    for (int t = 0; t < 24; t++) begin
      int unsigned sel;
      logic [23:0] addr;
      int len;
      sel  = $urandom % 4;
      addr = 24'($urandom);
      len  = 1 + int'($urandom % 5);
      case (sel)
        0: do_read(8'h03, addr, len);
        1: do_read(8'h0B, addr, len);
        2: do_id(len);
        default: do_bad(8'h10 + 8'($urandom % 8));
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule